// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block is a bit-serial master that reads one 16-bit word from a three-wire serial EEPROM. The host gives a one-cycle start pulse together with a word address. The block raises chip select, sends a fixed four-bit read command and then the six address bits on its serial data output, and clocks in the sixteen data bits the memory returns. At the end it returns the word on a parallel output with a one-cycle done strobe.

All serial clock phases have the same length, set by a parameter counted in system clocks. A second parameter picks whether the word appears as received or with its two bytes swapped. While a read is in progress the block reports busy and ignores further start pulses. It issues only the read transaction: it has no write, erase or write-enable commands and no register front end.

Top module: `mw_eeprom_reader`

## Requirements
- R1: `addr_i` is 8 bits wide. Only bits 5:0 are sent to the memory, and bits 7:6 have no effect on the transaction or on the word returned.
- R2: A `start_i` pulse seen while idle sets `cs_o` high with `sk_o` low in the next cycle. `busy_o` stays high until the done cycle, and `sk_o` is never high while `cs_o` is low.
- R3: The first four bits sent on `di_o`, as sampled at rising `sk_o`, are 0, 1, 1, 0 in that order.
- R4: Bits 5:0 of the address follow the command bits, most significant bit first.
- R5: Sixteen data bits are then read from `do_i`, most significant bit first. Each bit is taken at the end of the `sk_o` high phase: a value that `do_i` takes after `sk_o` has fallen has no effect.
- R6: Every high phase and every low phase of `sk_o` lasts HALF_PERIOD system clocks (at least 1). `di_o` changes only while `sk_o` is low.
- R7: After the last falling edge of `sk_o`, `cs_o` stays high with `sk_o` low for one more phase. Then `cs_o`, `sk_o` and `di_o` are all 0 and `done_o` pulses for one cycle. A start-to-done read takes 53*HALF_PERIOD cycles.
- R8: With SWAP_BYTES=0, `data_o` is the word as received (first bit received = bit 15). With SWAP_BYTES=1, the two bytes are exchanged. `data_o` changes only in the done cycle and holds its value in between.
- R9: A `start_i` pulse while `busy_o` is high is ignored: the address sent and the timing of the current read are unchanged.
- R10: While reset is asserted, `cs_o`, `sk_o`, `di_o`, `busy_o`, `done_o` and `data_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle read request |
| addr_i | input | 8 | Word address; only bits 5:0 are used |
| do_i | input | 1 | Serial data from the memory |
| cs_o | output | 1 | Memory chip select |
| sk_o | output | 1 | Serial clock to the memory |
| di_o | output | 1 | Serial data to the memory |
| busy_o | output | 1 | Read in progress |
| done_o | output | 1 | One-cycle strobe: read finished |
| data_o | output | 16 | Last word read |

## Verification
The assertions assume a single master owns the serial pins. They also assume reset is applied once at the start, so every clock phase they measure begins in a known idle state. The memory model in the bench drives `do_i` only from its own pin observations: it sets each data bit at rising `sk_o` and inverts it at falling `sk_o`, so a master that samples late reads wrong data. Start pulses are driven on the falling clock edge. Extra start pulses are placed in the middle of reads only, never in the done cycle, because a start in that cycle is a legitimate new request.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TAIL  = 2'd2
  } mw_state_e;

  localparam int unsigned CMD_BITS = 4;
  localparam logic [CMD_BITS-1:0] CMD_READ = 4'b0110;
endpackage

// File: rtl/mw_phase_timer.sv
module mw_phase_timer #(
  parameter int unsigned HALF_PERIOD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mw_word_fmt.sv
module mw_word_fmt #(
  parameter int unsigned DATA_W     = 16,
  parameter bit          SWAP_BYTES = 1'b0
) (
  input  logic [DATA_W-1:0] raw_i,
  output logic [DATA_W-1:0] word_o
);
  localparam int unsigned NBYTES = DATA_W / 8;

  generate
    if (SWAP_BYTES) begin : g_swap
      for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign word_o[b*8 +: 8] = raw_i[(NBYTES-1-b)*8 +: 8];
      end
    end else begin : g_pass
      assign word_o = raw_i;
    end
  endgenerate
endmodule

// File: rtl/mw_read_seq.sv
module mw_read_seq
  import mw_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              tick_i,
  input  logic              so_i,
  output logic              run_o,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o,
  output logic              end_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int unsigned OUT_BITS = CMD_BITS + ADDR_W;
  localparam int unsigned TOT_BITS = OUT_BITS + DATA_W;
  localparam int unsigned BIT_W    = $clog2(TOT_BITS);
  localparam logic [BIT_W-1:0] OUT_LAST = BIT_W'(OUT_BITS);
  localparam logic [BIT_W-1:0] TOT_LAST = BIT_W'(TOT_BITS - 1);

  mw_state_e            state_q;
  logic                 hi_q;
  logic [BIT_W-1:0]     bit_q;
  logic [OUT_BITS-1:0]  out_q;
  logic [DATA_W-1:0]    in_q;

  assign run_o = (state_q != ST_IDLE);
  assign cs_o  = run_o;
  assign sk_o  = (state_q == ST_SHIFT) && hi_q;
  assign di_o  = (state_q == ST_SHIFT) && (bit_q < OUT_LAST) && out_q[OUT_BITS-1];
  assign end_o = (state_q == ST_TAIL) && tick_i;
  assign rx_o  = in_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hi_q    <= 1'b0;
      bit_q   <= '0;
      out_q   <= '0;
      in_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_SHIFT;
            hi_q    <= 1'b0;
            bit_q   <= '0;
            out_q   <= {CMD_READ, addr_i};
          end
        end
        ST_SHIFT: begin
          if (tick_i) begin
            if (!hi_q) begin
              hi_q <= 1'b1;
            end else begin
              hi_q  <= 1'b0;
              out_q <= out_q << 1;
              if (bit_q >= OUT_LAST) in_q <= {in_q[DATA_W-2:0], so_i};
              if (bit_q == TOT_LAST) state_q <= ST_TAIL;
              else                   bit_q   <= bit_q + 1'b1;
            end
          end
        end
        ST_TAIL: begin
          if (tick_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader #(
  parameter int unsigned HALF_PERIOD = 4,
  parameter bit          SWAP_BYTES  = 1'b0,
  parameter int unsigned ADDR_IN_W   = 8,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned DATA_W      = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [ADDR_IN_W-1:0] addr_i,
  input  logic                 do_i,
  output logic                 cs_o,
  output logic                 sk_o,
  output logic                 di_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [DATA_W-1:0]    data_o
);
  logic              run;
  logic              tick;
  logic              seq_end;
  logic [DATA_W-1:0] rx_word;
  logic [DATA_W-1:0] fmt_word;
  logic              done_q;
  logic [DATA_W-1:0] data_q;

  mw_phase_timer #(.HALF_PERIOD(HALF_PERIOD)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (tick)
  );

  mw_read_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .addr_i  (addr_i[ADDR_W-1:0]),
    .tick_i  (tick),
    .so_i    (do_i),
    .run_o   (run),
    .cs_o    (cs_o),
    .sk_o    (sk_o),
    .di_o    (di_o),
    .end_o   (seq_end),
    .rx_o    (rx_word)
  );

  mw_word_fmt #(.DATA_W(DATA_W), .SWAP_BYTES(SWAP_BYTES)) u_fmt (
    .raw_i  (rx_word),
    .word_o (fmt_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      data_q <= '0;
    end else begin
      done_q <= seq_end;
      if (seq_end) data_q <= fmt_word;
    end
  end

  assign busy_o = run;
  assign done_o = done_q;
  assign data_o = data_q;
endmodule

// File: rtl/mw_eeprom_reader_chk.sv
module mw_eeprom_reader_chk #(
  parameter int unsigned HALF_PERIOD = 4,
  parameter int unsigned DATA_W      = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_o,
  input logic              sk_o,
  input logic              di_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] data_o
);
  logic        sk_prev_q;
  int unsigned hold_q;

  // length of the current sk level while selected
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sk_prev_q <= 1'b0;
      hold_q    <= 0;
    end else begin
      sk_prev_q <= sk_o;
      if (!cs_o)                hold_q <= 0;
      else if (sk_o != sk_prev_q) hold_q <= 1;
      else                      hold_q <= hold_q + 1;
    end
  end

  p_sk_needs_cs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sk_o |-> cs_o);

  p_cs_is_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o == busy_o);

  p_phase_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o && (sk_o != sk_prev_q)) |-> (hold_q == HALF_PERIOD));

  p_di_stable_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sk_o && sk_prev_q) |-> $stable(di_o));

  p_tail_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_o) |-> (hold_q == HALF_PERIOD) && !sk_prev_q);

  p_idle_lines_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!cs_o && !sk_o && !di_o));

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  p_data_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(data_o));
endmodule

bind mw_eeprom_reader mw_eeprom_reader_chk #(
  .HALF_PERIOD (HALF_PERIOD),
  .DATA_W      (DATA_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs_o   (cs_o),
  .sk_o   (sk_o),
  .di_o   (di_o),
  .busy_o (busy_o),
  .done_o (done_o),
  .data_o (data_o)
);

// File: tb/mw_eeprom_reader_tb_top.sv
`timescale 1ns/1ps
module mw_eeprom_reader_tb_top;
  localparam int unsigned H   = 2;
  localparam int unsigned DUR = 53 * H;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        do_i = 1'b0;
  logic        cs_w, sk_w, di_w, busy_w, done_w;
  logic [15:0] data_w;
  logic        cs_s, sk_s, di_s, busy_s, done_s;
  logic [15:0] data_s;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  mw_eeprom_reader #(.HALF_PERIOD(H), .SWAP_BYTES(1'b0)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i), .do_i(do_i),
    .cs_o(cs_w), .sk_o(sk_w), .di_o(di_w), .busy_o(busy_w), .done_o(done_w), .data_o(data_w)
  );

  mw_eeprom_reader #(.HALF_PERIOD(H), .SWAP_BYTES(1'b1)) dut_swap_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i), .do_i(do_i),
    .cs_o(cs_s), .sk_o(sk_s), .di_o(di_s), .busy_o(busy_s), .done_o(done_s), .data_o(data_s)
  );

  function automatic logic [15:0] mem_word(input logic [5:0] a);
    logic [15:0] w;
    w = 16'(a) * 16'h03B1;
    return w ^ 16'hA55A ^ {a, 10'h000};
  endfunction

  // memory model: drives bit at rising sk, corrupts it at falling sk
  bit          sel_seen = 1'b0;
  int          rise_n = 0;
  logic [9:0]  shreg = '0;
  logic [9:0]  hdr = '0;
  logic [15:0] word_m = '0;

  always @(posedge cs_w or negedge cs_w or posedge sk_w or negedge sk_w) begin
    if (cs_w && !sel_seen) begin
      sel_seen = 1'b1;
      rise_n = 0;
      shreg = '0;
    end else if (!cs_w) begin
      sel_seen = 1'b0;
    end else if (sk_w) begin
      rise_n++;
      if (rise_n <= 10) begin
        shreg = {shreg[8:0], di_w};
        if (rise_n == 10) begin
          hdr = shreg;
          word_m = mem_word(shreg[5:0]);
        end
      end else if (rise_n <= 26) begin
        do_i = word_m[26 - rise_n];
      end
    end else begin
      if (rise_n > 10) do_i = ~do_i;
    end
  end

  task automatic check(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_txn(input logic [7:0] a, input bit extra);
    int n;
    int width;
    int tail;
    bit prev_sk;
    bit width_ok;
    bit seen_done;
    logic [5:0] a6;
    logic [15:0] exp_w;
    a6 = a[5:0];
    exp_w = mem_word(a6);
    @(negedge clk_i);
    start_i = 1'b1;
    addr_i = a;
    @(negedge clk_i);
    start_i = 1'b0;
    addr_i = ~a;
    check("R2 select", cs_w && !sk_w && busy_w, {cs_w, sk_w, busy_w}, 3'b101);
    n = 1;
    width = 1;
    prev_sk = 1'b0;
    width_ok = 1'b1;
    tail = 0;
    seen_done = 1'b0;
    while (!seen_done && n < DUR + 40) begin
      @(negedge clk_i);
      n++;
      if (extra && n == 20) start_i = 1'b1;
      if (extra && n == 21) start_i = 1'b0;
      if (done_w) begin
        seen_done = 1'b1;
        tail = width;
      end else if (sk_w != prev_sk) begin
        if (width != H) width_ok = 1'b0;
        width = 1;
        prev_sk = sk_w;
      end else begin
        width++;
      end
    end
    check("R7 duration", (n - 1) == DUR, n - 1, DUR);
    check("R6 phase width", width_ok, width_ok, 1);
    check("R7 tail phase", tail == H, tail, H);
    check("R7 released", !cs_w && !sk_w && !di_w && !busy_w && done_w,
          {cs_w, sk_w, di_w, busy_w, done_w}, 5'b00001);
    check("R3 command bits", hdr[9:6] == 4'b0110, hdr[9:6], 4'b0110);
    check("R1 R4 address", hdr[5:0] == a6, hdr[5:0], a6);
    check("R5 word", data_w == exp_w, data_w, exp_w);
    check("R8 swapped word", data_s == {exp_w[7:0], exp_w[15:8]}, data_s, {exp_w[7:0], exp_w[15:8]});
    if (extra) check("R9 extra start ignored", hdr[5:0] == a6 && (n - 1) == DUR, hdr[5:0], a6);
    @(negedge clk_i);
    check("R7 done one cycle", !done_w && !busy_w, {done_w, busy_w}, 2'b00);
    repeat (3) @(negedge clk_i);
    check("R8 data held", data_w == exp_w, data_w, exp_w);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R10 reset outputs", !cs_w && !sk_w && !di_w && !busy_w && !done_w && data_w == 0,
          {cs_w, sk_w, di_w, busy_w, done_w}, 0);
    start_i = 1'b1;
    @(negedge clk_i);
    check("R10 start in reset", !cs_w && !busy_w, {cs_w, busy_w}, 0);
    start_i = 1'b0;
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R10 idle after reset", !cs_w && !busy_w && data_s == 0, {cs_w, busy_w}, 0);
    for (int a = 0; a < 64; a++) begin
      run_txn(8'(a) | 8'((a * 3) % 4 << 6), (a % 5) == 2);
    end
    // same low bits, different upper bits
    run_txn(8'h15, 1'b0);
    run_txn(8'hD5, 1'b1);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule